// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block turns one parallel character per request into an asynchronous serial frame on a single output line. A 7-bit framing word chooses the character length (5 to 8 bits), the stop period (one, one and a half, or two bit times), and an optional parity bit. That parity bit can be odd, even or held at a fixed level. A further bit of the same word forces the line to the spacing level. It does not disturb the frame sequencing, which keeps running underneath.

Timing comes from an external enable that pulses sixteen times per bit period. A character written with the load strobe goes into a one-entry holding register. The sequencer takes it from there when the line is free, or as soon as the current frame ends. The framing word is sampled at the moment a frame begins, so software may change it while a frame is being sent without corrupting that frame.

Top module: `async_tx`

## Requirements
- R1: During and straight after reset, `txd` is 1, `tx_busy` is 0 and `hold_empty` is 1.
- R2: `ctrl_word[1:0]` sets the character length: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. Only that many low bits of `wr_data` are sent.
- R3: A frame is one start bit at 0, then the data bits least-significant first, then the stop period at 1. Each bit lasts 16 `tick16` pulses, and clock cycles without a tick do not advance the frame. The line rests at 1 while idle.
- R4: The stop period depends on `ctrl_word[2]` and the length. With `ctrl_word[2]`=0 it is 16 ticks. With `ctrl_word[2]`=1 it is 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8 bits.
- R5: With `ctrl_word[3]`=1, one parity bit of 16 ticks is inserted between the last data bit and the stop period.
- R6: With parity on and `ctrl_word[5]`=0, the number of ones over the sent data bits plus parity is odd when `ctrl_word[4]`=0 and even when `ctrl_word[4]`=1.
- R7: With `ctrl_word[3]` and `ctrl_word[5]` both 1, the parity bit is the constant `~ctrl_word[4]`.
- R8: While `ctrl_word[6]`=1, `txd` is 0 with no delay. Frame timing, `tx_busy` and `hold_empty` behave exactly as without it.
- R9: A `wr_stb` pulse drives `hold_empty` low on the next cycle. If the line is idle, the start bit appears and `tx_busy` rises one cycle later, while `hold_empty` returns high.
- R10: A character held while a frame runs starts its start bit in the cycle right after the last stop tick, with `tx_busy` staying high.
- R11: The framing settings `ctrl_word[5:0]` are sampled when a frame starts. Later changes affect only the following frames.
- R12: A `wr_stb` while the holding register is already full replaces the held character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| ctrl_word | input | 7 | Framing word: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] fixed parity, [6] force spacing |
| wr_data | input | 8 | Character to send |
| wr_stb | input | 1 | Load strobe for `wr_data` |
| txd | output | 1 | Serial output line |
| tx_busy | output | 1 | High from the start bit to the end of the stop period |
| hold_empty | output | 1 | High when the holding register can accept a character |

## Verification
The holding flag drops one cycle after the strobe, and the start bit together with the busy flag follows one cycle after that. The bench checks each of these at the falling edge that ends that cycle. After that, every bit edge falls exactly on the sixteenth tick. The bench therefore finds the first low sample and then samples each bit 8, 24, 40 ... tick-cycles later, at the middle of each bit. It also counts how many falling edges see busy high and compares that count with the expected frame length in ticks. The force-spacing bit acts within the same cycle, so its effect is checked on the sample taken just after the control change.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // framing fields captured at frame start (force-spacing bit excluded)
  typedef struct packed {
    logic       fixed_par;
    logic       even_sel;
    logic       par_on;
    logic       long_stop;
    logic [1:0] len_code;
  } tx_frame_t;

  // index of the final data bit: 4..7 for lengths 5..8
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
    return 3'd4 + {1'b0, len_code};
  endfunction

  // stop period in ticks for a given oversampling ratio
  function automatic int stop_ticks(input tx_frame_t f, input int os);
    if (!f.long_stop)           return os;
    else if (f.len_code == 2'b00) return os + os / 2;
    else                        return 2 * os;
  endfunction

  // parity bit to transmit for a character under the given framing
  function automatic logic parity_of(input tx_frame_t f, input logic [7:0] d);
    logic [2:0] last;
    logic       ones;
    last = last_bit_idx(f.len_code);
    ones = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (3'(i) <= last) ones = ones ^ d[i];
    end
    if (f.fixed_par) return ~f.even_sel;
    else if (f.even_sel) return ones;
    else return ~ones;
  endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic [DW-1:0] dout,
  output logic          full
);

  logic [DW-1:0] data_q;
  logic          full_q;

  // a load wins over a take in the same cycle, so the newer character stays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      data_q <= din;
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign dout = data_q;
  assign full = full_q;

endmodule

// File: rtl/async_tx_seq.sv
module async_tx_seq
  import async_tx_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8,
  localparam int CW = $clog2(2 * OS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  tx_frame_t     frame_in,
  output logic          take,
  output logic          line_bit,
  output logic          busy,
  output logic          frame_start,
  output logic          frame_done,
  output tx_state_e     state,
  output tx_frame_t     frame_cap
);

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     tick_cnt_q;
  logic [2:0]        bit_idx_q, bit_idx_d;
  logic [DW-1:0]     shreg_q;
  logic              par_q;
  tx_frame_t         frame_q;
  logic [CW-1:0]     bit_limit;
  logic              bit_end;

  // length of the current bit in ticks, minus one
  always_comb begin
    if (state_q == ST_STOP) bit_limit = CW'(stop_ticks(frame_q, OS) - 1);
    else                    bit_limit = CW'(OS - 1);
  end

  assign bit_end     = tick && (state_q != ST_IDLE) && (tick_cnt_q == bit_limit);
  assign frame_done  = bit_end && (state_q == ST_STOP);
  assign frame_start = hold_full && ((state_q == ST_IDLE) || frame_done);

  always_comb begin
    state_d   = state_q;
    bit_idx_d = bit_idx_q;
    unique case (state_q)
      ST_IDLE:  if (hold_full) state_d = ST_START;
      ST_START: if (bit_end) begin
                  state_d   = ST_DATA;
                  bit_idx_d = 3'd0;
                end
      ST_DATA:  if (bit_end) begin
                  if (bit_idx_q == last_bit_idx(frame_q.len_code))
                    state_d = frame_q.par_on ? ST_PAR : ST_STOP;
                  else
                    bit_idx_d = bit_idx_q + 3'd1;
                end
      ST_PAR:   if (bit_end) state_d = ST_STOP;
      ST_STOP:  if (bit_end) state_d = hold_full ? ST_START : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      frame_q    <= '0;
    end else begin
      state_q   <= state_d;
      bit_idx_q <= bit_idx_d;
      if (frame_start) begin
        frame_q <= frame_in;
        shreg_q <= hold_data;
        par_q   <= parity_of(frame_in, hold_data);
      end else if (bit_end && state_q == ST_DATA) begin
        shreg_q <= shreg_q >> 1;
      end
      if (frame_start || bit_end)
        tick_cnt_q <= '0;
      else if (tick && state_q != ST_IDLE)
        tick_cnt_q <= tick_cnt_q + CW'(1);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign take      = frame_start;
  assign busy      = (state_q != ST_IDLE);
  assign state     = state_q;
  assign frame_cap = frame_q;

endmodule

// File: rtl/async_tx_line.sv
module async_tx_line (
  input  logic force_space,
  input  logic line_bit,
  output logic txd
);

  // spacing override acts on the pin only; sequencing is untouched
  assign txd = line_bit & ~force_space;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [6:0] ctrl_word,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  output logic       txd,
  output logic       tx_busy,
  output logic       hold_empty
);

  localparam int DW = 8;

  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          line_bit;
  logic          frame_start;
  logic          frame_done;
  tx_state_e     seq_state;
  tx_frame_t     frame_in;
  tx_frame_t     cfg_cap;

  assign frame_in = tx_frame_t'(ctrl_word[5:0]);

  async_tx_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_stb),
    .din   (wr_data),
    .take  (take),
    .dout  (hold_data),
    .full  (hold_full)
  );

  async_tx_seq #(.OS(OS), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .frame_in    (frame_in),
    .take        (take),
    .line_bit    (line_bit),
    .busy        (tx_busy),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .state       (seq_state),
    .frame_cap   (cfg_cap)
  );

  async_tx_line u_line (
    .force_space (ctrl_word[6]),
    .line_bit    (line_bit),
    .txd         (txd)
  );

  assign hold_empty = ~hold_full;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       wr_stb,
  input logic [6:0] ctrl_word,
  input logic       txd,
  input logic       tx_busy,
  input logic       hold_empty,
  input logic       frame_start,
  input logic       frame_done,
  input logic [2:0] seq_state,
  input logic [5:0] cfg_cap
);

  AST_SPACING_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[6] |-> !txd); // R8

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !ctrl_word[6]) |-> txd); // R3

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && !ctrl_word[6]) |-> !txd); // R3

  AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && tx_busy && !frame_start) |=> $stable(seq_state)); // R3

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !hold_empty); // R9

  AST_START_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!hold_empty)); // R9

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !hold_empty) |=> tx_busy); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !frame_start) |=> $stable(cfg_cap)); // R11

endmodule

bind async_tx async_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .wr_stb      (wr_stb),
  .ctrl_word   (ctrl_word),
  .txd         (txd),
  .tx_busy     (tx_busy),
  .hold_empty  (hold_empty),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .seq_state   (seq_state),
  .cfg_cap     (cfg_cap)
);

// File: tb/async_tx_bench.sv
module async_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [6:0] ctrl_word = 7'h03;
  logic [7:0] wr_data = 8'h00;
  logic       wr_stb = 1'b0;
  logic       txd, tx_busy, hold_empty;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_div = 1;
  int tcnt = 0;
  int run_len = 0;
  int last_len = 0;

  always #10 clk = ~clk;  // 50 MHz

  async_tx u_async_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .ctrl_word  (ctrl_word),
    .wr_data    (wr_data),
    .wr_stb     (wr_stb),
    .txd        (txd),
    .tx_busy    (tx_busy),
    .hold_empty (hold_empty)
  );

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    tick16 <= (tcnt == 0);
    tcnt   <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
  end

  // busy run-length monitor
  always @(negedge clk) begin
    if (tx_busy) run_len = run_len + 1;
    else begin
      if (run_len != 0) last_len = run_len;
      run_len = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // bench-side receiver: sample each bit at its middle
  task automatic rx_frame(input int nbits, input bit par_on, input int m,
                          output logic [7:0] d, output logic p,
                          output logic start_ok, output logic stop_ok,
                          output int wait_n);
    wait_n = 0;
    d = 8'h00;
    p = 1'b0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (txd !== 1'b0 && wait_n < 2000);
    repeat (8 * m - 1) @(negedge clk);
    start_ok = (txd === 1'b0);
    for (int i = 0; i < nbits; i++) begin
      repeat (16 * m) @(negedge clk);
      d[i] = txd;
    end
    if (par_on) begin
      repeat (16 * m) @(negedge clk);
      p = txd;
    end
    repeat (16 * m) @(negedge clk);
    stop_ok = (txd === 1'b1);
  endtask

  task automatic wait_idle_len(output int len);
    int guard = 0;
    while (tx_busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    len = last_len;
  endtask

  // {ctrl, data, frame length in ticks, parity: 2 = none, else expected bit}
  localparam logic [33:0] VEC [12] = '{
    {8'h03, 8'hA5, 16'd160, 2'd2},
    {8'h00, 8'h13, 16'd112, 2'd2},
    {8'h04, 8'h1F, 16'd120, 2'd2},
    {8'h07, 8'h3C, 16'd176, 2'd2},
    {8'h0B, 8'hA5, 16'd176, 2'd1},
    {8'h1B, 8'hA5, 16'd176, 2'd0},
    {8'h09, 8'hC7, 16'd144, 2'd0},
    {8'h1E, 8'h81, 16'd176, 2'd1},
    {8'h3B, 8'hFE, 16'd176, 2'd0},
    {8'h2B, 8'h01, 16'd176, 2'd1},
    {8'h0C, 8'hE0, 16'd136, 2'd1},
    {8'h01, 8'h2A, 16'd128, 2'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic p, s_ok, e_ok, s_ok2, e_ok2;
    int wn, wn2, len, ones;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 txd in reset", 32'(txd), 1);
    check("R1 busy in reset", 32'(tx_busy), 0);
    check("R1 hold_empty in reset", 32'(hold_empty), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 txd after reset", 32'(txd), 1);
    check("R1 busy after reset", 32'(tx_busy), 0);

    // table walk
    for (int v = 0; v < 12; v++) begin
      logic [7:0] c, dat, mask;
      int nb;
      c   = VEC[v][33:26];
      dat = VEC[v][25:18];
      nb  = 5 + int'(c[1:0]);
      mask = 8'hFF >> (8 - nb);
      ctrl_word = c[6:0];
      @(negedge clk);
      wr_data = dat;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
      check("R9 hold_empty low after load", 32'(hold_empty), 0);
      check("R9 line still idle", 32'(txd), 1);
      rx_frame(nb, c[3], 1, d, p, s_ok, e_ok, wn);
      check("R9 start one cycle after", 32'(wn), 1);
      check("R3 start bit", 32'(s_ok), 1);
      check("R2/R3 data bits", 32'(d), 32'(dat & mask));
      if (c[3]) check(c[5] ? "R7 fixed parity" : "R6 parity", 32'(p), 32'(VEC[v][1:0]));
      check("R3 stop level", 32'(e_ok), 1);
      wait_idle_len(len);
      check("R4/R5 frame length", 32'(len), 32'(VEC[v][17:2]));
      check("R3 idle high", 32'(txd), 1);
    end

    // R6 independent parity cross-check for an odd frame
    ones = $countones(8'hA5);
    check("R6 odd total", 32'((ones + 1) % 2), 1);

    // R10 / R12 back-to-back with replacement of the held character
    ctrl_word = 7'h03;
    load(8'h11);
    fork
      rx_frame(8, 1'b0, 1, d, p, s_ok, e_ok, wn);
      begin
        repeat (30) @(negedge clk);
        wr_data = 8'h22; wr_stb = 1'b1;
        @(negedge clk);
        wr_data = 8'h33;
        @(negedge clk);
        wr_stb = 1'b0;
        check("R12 hold full while busy", 32'(hold_empty), 0);
      end
    join
    check("R10 first char", 32'(d), 32'h11);
    rx_frame(8, 1'b0, 1, d2, p, s_ok2, e_ok2, wn2);
    check("R10 gap to second start", 32'(wn2), 9);
    check("R12 replaced char sent", 32'(d2), 32'h33);
    wait_idle_len(len);
    check("R10 busy spans both frames", 32'(len), 320);
    check("R12 holding empty at end", 32'(hold_empty), 1);

    // R11 mid-frame control change
    ctrl_word = 7'h03;
    load(8'h5A);
    fork
      rx_frame(8, 1'b0, 1, d, p, s_ok, e_ok, wn);
      begin
        repeat (20) @(negedge clk);
        ctrl_word = 7'h00;
      end
    join
    check("R11 old framing data", 32'(d), 32'h5A);
    wait_idle_len(len);
    check("R11 old framing length", 32'(len), 160);
    load(8'h1F);
    rx_frame(5, 1'b0, 1, d, p, s_ok, e_ok, wn);
    check("R11 new framing data", 32'(d), 32'h1F);
    wait_idle_len(len);
    check("R11 new framing length", 32'(len), 112);

    // R8 force spacing
    ctrl_word = 7'h43;
    @(negedge clk);
    check("R8 spacing while idle", 32'(txd), 0);
    check("R8 idle busy", 32'(tx_busy), 0);
    load(8'h55);
    @(negedge clk);
    check("R8 busy unaffected", 32'(tx_busy), 1);
    ones = 0;
    while (tx_busy) begin
      if (txd !== 1'b0) ones++;
      @(negedge clk);
    end
    @(negedge clk);
    check("R8 line held low", 32'(ones), 0);
    check("R8 frame timing kept", 32'(last_len), 160);
    ctrl_word = 7'h03;
    @(negedge clk);
    check("R8 released idle high", 32'(txd), 1);
    load(8'hC3);
    rx_frame(8, 1'b0, 1, d, p, s_ok, e_ok, wn);
    check("R8 next frame clean", 32'(d), 32'hC3);
    wait_idle_len(len);

    // R3 slower tick: one tick every third cycle
    tick_div = 3;
    load(8'h96);
    rx_frame(8, 1'b0, 3, d, p, s_ok, e_ok, wn);
    check("R3 data at slow tick", 32'(d), 32'h96);
    check("R3 stop at slow tick", 32'(e_ok), 1);
    wait_idle_len(len);
    check("R3 slow frame length", 32'(len >= 478 && len <= 480), 1);
    tick_div = 1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule